// File: doc/BRIEF.md
# Boundary-Scan Test Port with Reduced Instruction Set

This block is the serial test port of a memory device. Its state machine is the usual sixteen-state machine, stepped by the test clock and a mode-select input. A three-bit instruction register chooses which serial path sits between the data input and the data output. There are three data paths: a single bypass bit, a 32-bit identification word, and a boundary register of configurable length. The boundary register only takes snapshots of a parallel vector of pin values.

The instruction set does not fully comply with the boundary-scan standard. The all-zeros code samples the pins, as the sample instruction does, and also floats the device outputs. A separate instruction samples the pins and floats the outputs. Update-DR never moves scanned data anywhere, because no preload stage exists. Three codes are reserved and act as bypass. Scanned data never reaches a functional pin. The only effect the block has on the device is one output-disable flag.

Top module: `scan_tap_port`

## Requirements
- R1: The state machine follows the standard sixteen-state transitions on each rising test-clock edge. From any state, five rising edges with the mode-select input high reach Test-Logic-Reset.
- R2: A low level on trst_n sampled at a rising test-clock edge forces Test-Logic-Reset and makes the identification instruction current. The output-disable flag goes low.
- R3: After either kind of reset, the identification instruction (code 001) is current. A Shift-DR pass then returns the 32-bit ID_VALUE parameter, bit 0 first.
- R4: The instruction register is 3 bits wide and shifts toward the data output, bit 0 first. Capture-IR loads the value 001, so 1, 0, 0 is shifted out. A shifted code becomes current only at the rising edge that leaves Update-IR.
- R5: The codes are 000 sample-and-float, 001 identification, 010 float-sample, 100 sample, and 111 bypass. The reserved codes 011, 101 and 110 behave exactly as bypass.
- R6: Under codes 000, 010 and 100, Capture-DR loads the pin vector into the boundary register. Shift-DR then returns it, pin 0 first.
- R7: out_hiz is high exactly while the current instruction is 000 or 010.
- R8: Update-DR loads nothing. Under code 100, data scanned in leaves out_hiz unchanged, and the next capture returns the pins rather than the scanned data.
- R9: Under bypass and the reserved codes, Capture-DR loads 0 and Shift-DR delays the data input by one bit.
- R10: tdo and tdo_oe change on the falling test-clock edge. tdo_oe is high only in Shift-IR and Shift-DR, and tdo is 0 whenever tdo_oe is low.
- R11: A data shift can pass through Pause-DR and Exit2-DR and resume without losing or repeating a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising tck |
| tms | input | 1 | Mode select for the state machine |
| tdi | input | 1 | Serial data input |
| pin_snap | input | BSR_W | Parallel pin values for boundary capture |
| tdo | output | 1 | Serial data output |
| tdo_oe | output | 1 | Output enable for tdo |
| out_hiz | output | 1 | Forces the device's functional outputs to high impedance |

## Verification
Embedded assertions check the following on every clock:
- the reset reaction and the five-ones escape of the state machine;
- the Capture-IR pattern;
- that the current instruction changes only at Update-IR or on reset;
- the one-bit bypass delay and the boundary capture;
- that tdo_oe is confined to the two shift states.

The bench sweeps all eight instruction codes with several pin patterns. Only these scenarios can show the complete shifted words, the bit order, the reserved codes acting as bypass, the inert Update-DR under sample, and a shift that resumes across a pause.

// File: rtl/tap_pkg.sv
// Shared definitions for the boundary-scan test port.
// Assumes a 3-bit instruction register; the code values are fixed by the decode.
package tap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BSR
    } dr_path_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_SAMPLE_FLOAT = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT        = 3'b001;
    localparam logic [IR_W-1:0] OP_FLOAT_SAMPLE = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE       = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS       = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE      = 3'b001;

    // Maps an instruction code to its serial data path; reserved codes map to bypass.
    function automatic dr_path_e op_path(input logic [IR_W-1:0] op);
        case (op)
            OP_SAMPLE_FLOAT, OP_FLOAT_SAMPLE, OP_SAMPLE: op_path = PATH_BSR;
            OP_IDENT:                                    op_path = PATH_ID;
            default:                                     op_path = PATH_BYP;
        endcase
    endfunction

    // True for the instructions that float the functional outputs.
    function automatic logic op_floats(input logic [IR_W-1:0] op);
        op_floats = (op == OP_SAMPLE_FLOAT) || (op == OP_FLOAT_SAMPLE);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state test-port controller stepped on rising tck.
// Assumes trst_n is synchronous to tck; a low level forces Test-Logic-Reset.
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;
    logic [2:0] ones_run;

    // Next-state selection from the current state and tms.
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // Saturating count of consecutive tms-high edges, used by the escape check.
    always_ff @(posedge tck) begin
        if (!trst_n)       ones_run <= 3'd0;
        else if (!tms)     ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    // R2: reset input lands in Test-Logic-Reset.
    p_trst_to_reset_r2: assert property (@(posedge tck) !trst_n |=> state == ST_TLR);

    // R1: five tms-high edges reach Test-Logic-Reset from anywhere.
    p_five_ones_escape_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> state == ST_TLR);

endmodule

// File: rtl/tap_ir.sv
// Instruction register: shift stage plus current-instruction stage and decode.
// Assumes IDCODE is restored on reset or in Test-Logic-Reset; update happens
// on the rising edge that leaves Update-IR.
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_sout,
    output dr_path_e   path,
    output logic       out_hiz
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_cur;

    // Shift stage: capture the fixed pattern, then shift toward tdo.
    always_ff @(posedge tck) begin
        if (!trst_n)                 ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state == ST_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Current instruction: identification on reset, new code at Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir_cur <= OP_IDENT;
        else if (state == ST_UPD_IR)    ir_cur <= ir_sh;
    end

    assign ir_sout = ir_sh[0];
    assign path    = op_path(ir_cur);
    assign out_hiz = op_floats(ir_cur);

    // R4: Capture-IR leaves 001 in the shift stage.
    p_ir_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_IR |=> ir_sh == IR_CAPTURE);

    // R4: the current instruction moves only after Update-IR or a reset.
    p_ir_commit_r4: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir_cur) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR || !$past(trst_n)));

    // R7: floating the outputs implies the boundary path is selected.
    p_float_on_bsr_r7: assert property (@(posedge tck) disable iff (!trst_n)
        out_hiz |-> path == PATH_BSR);

endmodule

// File: rtl/tap_dr.sv
// Data registers: bypass bit, identification word and boundary snapshot chain.
// Assumes pin_snap is already stable at tck; no preload stage exists.
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_W    = 18,
    parameter logic [31:0] ID_VALUE = 32'h2D61_50A7
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_e       state,
    input  dr_path_e         path,
    input  logic [BSR_W-1:0] pin_snap,
    output logic             dr_sout
);

    localparam int ID_W = 32;

    logic             byp;
    logic [ID_W-1:0]  id_sh;
    logic [BSR_W-1:0] bsr;
    logic [BSR_W-1:0] chain_in;
    logic             cap_now;
    logic             shf_now;

    assign cap_now = (state == ST_CAP_DR);
    assign shf_now = (state == ST_SHF_DR);

    // Bypass bit: cleared at capture, takes tdi while shifting.
    always_ff @(posedge tck) begin
        if (!trst_n)                          byp <= 1'b0;
        else if (cap_now && path == PATH_BYP) byp <= 1'b0;
        else if (shf_now && path == PATH_BYP) byp <= tdi;
    end

    // Identification word: loaded at capture, shifted bit 0 first.
    always_ff @(posedge tck) begin
        if (!trst_n)                         id_sh <= ID_VALUE;
        else if (cap_now && path == PATH_ID) id_sh <= ID_VALUE;
        else if (shf_now && path == PATH_ID) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

    // Boundary chain: one cell per pin, each capturing its pin or taking its upper neighbour.
    for (genvar k = 0; k < BSR_W; k++) begin : g_cell
        logic q;
        if (k == BSR_W - 1) begin : g_top
            assign chain_in[k] = tdi;
        end else begin : g_mid
            assign chain_in[k] = bsr[k+1];
        end
        // Cell update: capture, shift or hold.
        always_ff @(posedge tck) begin
            if (!trst_n)                          q <= 1'b0;
            else if (cap_now && path == PATH_BSR) q <= pin_snap[k];
            else if (shf_now && path == PATH_BSR) q <= chain_in[k];
        end
        assign bsr[k] = q;
    end

    // Serial output of whichever path is selected.
    always_comb begin
        case (path)
            PATH_ID:  dr_sout = id_sh[0];
            PATH_BSR: dr_sout = bsr[0];
            default:  dr_sout = byp;
        endcase
    end

    // R9: in bypass the bit just shifted in is the previous tdi.
    p_byp_delay_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (shf_now && path == PATH_BYP) |=> byp == $past(tdi));

    // R6: a boundary capture holds the pins seen at that edge.
    p_bsr_capture_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_now && path == PATH_BSR) |=> bsr == $past(pin_snap));

endmodule

// File: rtl/scan_tap_port.sv
// Top of the boundary-scan test port: state machine, instruction and data
// registers, and the falling-edge output stage. Assumes a single test clock.
module scan_tap_port
    import tap_pkg::*;
#(
    parameter int          BSR_W    = 18,
    parameter logic [31:0] ID_VALUE = 32'h2D61_50A7
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BSR_W-1:0] pin_snap,
    output logic             tdo,
    output logic             tdo_oe,
    output logic             out_hiz
);

    tap_state_e state;
    dr_path_e   path;
    logic       ir_sout;
    logic       dr_sout;
    logic       shift_now;
    logic       sout;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (state),
        .ir_sout (ir_sout),
        .path    (path),
        .out_hiz (out_hiz)
    );

    tap_dr #(
        .BSR_W    (BSR_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (state),
        .path     (path),
        .pin_snap (pin_snap),
        .dr_sout  (dr_sout)
    );

    assign shift_now = (state == ST_SHF_IR) || (state == ST_SHF_DR);
    assign sout      = (state == ST_SHF_IR) ? ir_sout : dr_sout;

    // Output stage: present the serial bit and its enable on the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_now;
            tdo    <= shift_now ? sout : 1'b0;
        end
    end

    // R10: the enable is only ever seen during a shift state.
    p_oe_window_r10: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

    // R10: a disabled output stays low.
    p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

endmodule

// File: tb/tb_scan_tap_port.sv
module tb_scan_tap_port;

    localparam int          BSR_W = 18;
    localparam logic [31:0] ID    = 32'h2D61_50A7;

    logic             tck = 1'b0;
    logic             trst_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [BSR_W-1:0] pin_snap = '0;
    logic             tdo;
    logic             tdo_oe;
    logic             out_hiz;

    int n_chk = 0;
    int n_bad = 0;
    logic hiz_exp = 1'b0;

    scan_tap_port #(.BSR_W(BSR_W), .ID_VALUE(ID)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .pin_snap(pin_snap), .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz)
    );

    always #5 tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic d);
        @(negedge tck); #1;
        tms = t;
        tdi = d;
    endtask

    task automatic reset_pin();
        trst_n = 1'b0;
        tms = 1'b0;
        repeat (3) @(negedge tck);
        #1;
        trst_n = 1'b1;
        tms = 1'b0;
        hiz_exp = 1'b0;
    endtask

    task automatic reset_tms();
        repeat (5) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        hiz_exp = 1'b0;
    endtask

    // From Run-Test/Idle: load a code, return the captured IR bits, end in Run-Test/Idle.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic new_hiz;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge tck); #1;
            cap[i] = tdo;
            chk("R10 oe in Shift-IR", {63'd0, tdo_oe}, 64'd1);
            tdi = code[i];
            tms = (i == 2);
        end
        step(1'b1, 1'b0);
        @(negedge tck); #1;
        chk("R4 no effect before Update-IR", {63'd0, out_hiz}, {63'd0, hiz_exp});
        tms = 1'b0;
        tdi = 1'b0;
        new_hiz = (code == 3'b000) || (code == 3'b010);
        @(negedge tck); #1;
        chk("R7 out_hiz after update", {63'd0, out_hiz}, {63'd0, new_hiz});
        chk("R10 oe low in idle", {63'd0, tdo_oe}, 64'd0);
        hiz_exp = new_hiz;
    endtask

    // From Run-Test/Idle: shift n bits, optionally pausing after pause_at bits.
    task automatic shift_dr(input int n, input logic [63:0] din, input int pause_at,
                            output logic [63:0] dout);
        dout = '0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            @(negedge tck); #1;
            dout[i] = tdo;
            if (tdo_oe !== 1'b1) chk("R10 oe in Shift-DR", {63'd0, tdo_oe}, 64'd1);
            tdi = din[i];
            tms = (i == n - 1) || (i + 1 == pause_at);
            if (i + 1 == pause_at && i != n - 1) begin
                step(1'b0, 1'b0);
                step(1'b0, 1'b0);
                chk("R11 oe low in Pause-DR", {63'd0, tdo_oe}, 64'd0);
                step(1'b1, 1'b0);
                step(1'b0, 1'b0);
            end
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [63:0] din;
        logic [63:0] mask;
        logic [31:0] tmp;

        reset_pin();
        @(negedge tck); #1;
        chk("R2 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
        chk("R2 reset out_hiz", {63'd0, out_hiz}, 64'd0);
        chk("R10 reset tdo", {63'd0, tdo}, 64'd0);
        shift_dr(32, 64'h0123_4567_89AB_CDEF, 0, dout);
        chk("R3 id after reset", dout & 64'hFFFF_FFFF, {32'd0, ID});

        // R5 R6 R9: every code with two pin patterns.
        for (int code = 0; code < 8; code++) begin
            for (int k = 0; k < 2; k++) begin
                load_ir(code[2:0], cap);
                chk("R4 capture pattern", {61'd0, cap}, 64'd1);
                tmp = 32'h9E37_79B9 * (code * 2 + k + 1);
                pin_snap = tmp[BSR_W-1:0] ^ tmp[31:32-BSR_W];
                din = {tmp, ~tmp};
                if (code == 0 || code == 2 || code == 4) begin
                    mask = (64'd1 << BSR_W) - 1;
                    shift_dr(BSR_W, din, 0, dout);
                    chk("R6 boundary snapshot", dout & mask, {{(64-BSR_W){1'b0}}, pin_snap});
                    chk("R7 out_hiz held", {63'd0, out_hiz}, {63'd0, hiz_exp});
                end else if (code == 1) begin
                    shift_dr(32, din, 0, dout);
                    chk("R3 id word", dout & 64'hFFFF_FFFF, {32'd0, ID});
                end else begin
                    shift_dr(8, din, 0, dout);
                    chk("R9 R5 bypass delay", dout & 64'hFF, {din[62:0], 1'b0} & 64'hFF);
                end
            end
        end

        // R8: under sample, Update-DR is inert; recapture shows pins.
        load_ir(3'b100, cap);
        pin_snap = 18'h2A5C3;
        shift_dr(BSR_W, 64'h3FFFF, 0, dout);
        chk("R8 first capture", dout & ((64'd1 << BSR_W) - 1), 64'h2A5C3);
        chk("R8 out_hiz unchanged", {63'd0, out_hiz}, 64'd0);
        pin_snap = 18'h01F0E;
        shift_dr(BSR_W, 64'h0, 0, dout);
        chk("R8 recapture pins", dout & ((64'd1 << BSR_W) - 1), 64'h01F0E);

        // R1: from sample-and-float, five tms ones restore identification.
        load_ir(3'b000, cap);
        reset_tms();
        @(negedge tck); #1;
        chk("R1 out_hiz cleared", {63'd0, out_hiz}, 64'd0);
        shift_dr(32, 64'd0, 0, dout);
        chk("R1 id after tms reset", dout & 64'hFFFF_FFFF, {32'd0, ID});

        // R11: pause in the middle of an id shift.
        shift_dr(32, 64'd0, 13, dout);
        chk("R11 id across pause", dout & 64'hFFFF_FFFF, {32'd0, ID});

        // R2: reset input from float-sample clears the flag and restores id.
        load_ir(3'b010, cap);
        reset_pin();
        @(negedge tck); #1;
        chk("R2 out_hiz after trst", {63'd0, out_hiz}, 64'd0);
        shift_dr(32, 64'd0, 0, dout);
        chk("R2 id after trst", dout & 64'hFFFF_FFFF, {32'd0, ID});

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule